// File: doc/BRIEF.md
# Burst Microcode Address Sequencer

This block forms the address of a wide microcode control store for a processor in which every instruction takes exactly four clocks. The operation code is valid on its input only during the first clock of an instruction. The block captures it there, and a two-bit step count then advances by itself through the other three clocks, as a burst memory would do internally. Two upper address bits choose one of four alternate microcode versions of each operation. They come from an external variant input that is sampled together with the operation code.

The address is 13 bits: step in bits 1:0, operation code in bits 10:2 and variant in bits 12:11. A behavioural control-store model inside the block turns this address into a 72-bit control word. The testbench loads the model through a write port. To keep the model small, it resolves only the low six operation-code bits, so codes that differ only in the upper three bits share a word. Strobes mark the first and the last clock of each instruction.

Top module: `ucode_seq_top`

## Requirements
- R1: The address is {variant[1:0], opcode[8:0], step[1:0]}, with step in bits 1:0, opcode in bits 10:2 and variant in bits 12:11, and `step_o` equals address bits 1:0.
- R2: Steps advance 0, 1, 2, 3, 0 on successive clocks while reset is low. Reset holds the step at 0.
- R3: In step 0 the opcode bits follow `opc_i` in the same cycle. In steps 1 to 3 `opc_i` has no effect, and the bits keep the value captured in step 0.
- R4: In step 0 the variant bits follow `quad_i` in the same cycle. In steps 1 to 3 `quad_i` has no effect, and the bits keep the value captured in step 0.
- R5: `first_o` is high exactly in step 0 and `last_o` is high exactly in step 3. They are never high together, and step 0 follows a cycle with `last_o` high.
- R6: A clock with `ld_en` high stores `ld_data` at the word selected by `ld_addr`. From the next cycle, `ucode_o` shows that word whenever the current address selects it.
- R7: The store selects a word by {address[12:11], address[7:0]}, so two addresses that differ only in bits 10:8 (opcode bits 8:6) read the same word.
- R8: A synchronous reset raised in any step returns the step to 0 on the next clock, so the following clock begins a new instruction. Reset does not alter store contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opc_i | input | 9 | Operation code, valid in step 0 only |
| quad_i | input | 2 | Variant select, valid in step 0 only |
| ld_en | input | 1 | Control-store write enable |
| ld_addr | input | 13 | Control-store write address |
| ld_data | input | 72 | Control-store write data |
| ucode_addr_o | output | 13 | Current control-store address |
| ucode_o | output | 72 | Control word at the current address |
| step_o | output | 2 | Current step within the instruction |
| first_o | output | 1 | High in step 0 |
| last_o | output | 1 | High in step 3 |

## Verification
Two cases are hard to reach from the ports. The first is to show that the captured opcode and variant really ignore their inputs in steps 1 to 3. The stimulus therefore drives different values on `opc_i` and `quad_i` in every non-first step, and it sweeps all 512 opcodes under all four variants. The second is to show that a write takes effect in the very next step of an instruction. The bench writes, during step 0, the word that an aliased address reaches in step 1. It then raises reset in step 2 and checks that the step returns to 0 while the store contents remain.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  typedef enum logic [1:0] {
    STEP_FIRST = 2'd0,
    STEP_B     = 2'd1,
    STEP_C     = 2'd2,
    STEP_LAST  = 2'd3
  } step_e;
endpackage

// File: rtl/ucs_step_ctr.sv
module ucs_step_ctr #(
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STEP_W-1:0] step,
  output logic              first,
  output logic              last
);
  logic [STEP_W-1:0] step_q;

  function automatic logic [STEP_W-1:0] next_step(input logic [STEP_W-1:0] s);
    return s + STEP_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= next_step(step_q);
  end

  assign step  = step_q;
  assign first = (step_q == '0);
  assign last  = (step_q == '1);

  assert_step_adv_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> step_q == STEP_W'($past(step_q) + 1'b1));
  assert_rst_step_R8: assert property (@(posedge clk)
    rst |=> step_q == '0);
endmodule

// File: rtl/ucs_addr_form.sv
module ucs_addr_form #(
  parameter int OPC_W  = 9,
  parameter int QUAD_W = 2,
  parameter int STEP_W = 2,
  localparam int AW    = OPC_W + QUAD_W + STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              first,
  input  logic              last,
  input  logic [STEP_W-1:0] step,
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [QUAD_W-1:0] quad_i,
  output logic [AW-1:0]     addr
);
  logic [OPC_W-1:0]  opc_q, opc_use;
  logic [QUAD_W-1:0] quad_q, quad_use;

  function automatic logic [AW-1:0] compose(input logic [QUAD_W-1:0] q,
                                            input logic [OPC_W-1:0]  o,
                                            input logic [STEP_W-1:0] s);
    return {q, o, s};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q  <= '0;
      quad_q <= '0;
    end else if (first) begin
      opc_q  <= opc_i;
      quad_q <= quad_i;
    end
  end

  assign opc_use  = first ? opc_i  : opc_q;
  assign quad_use = first ? quad_i : quad_q;
  assign addr     = compose(quad_use, opc_use, step);

  assert_opc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(opc_use));
  assert_quad_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(quad_use));
endmodule

// File: rtl/ucs_store.sv
module ucs_store #(
  parameter int AW     = 13,
  parameter int DW     = 72,
  parameter int QUAD_W = 2,
  parameter int STEP_W = 2,
  parameter int SOP_W  = 6,
  localparam int IW    = QUAD_W + SOP_W + STEP_W,
  localparam int DEPTH = 1 << IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] wr_idx, rd_idx;

  function automatic logic [IW-1:0] idx_of(input logic [AW-1:0] a);
    return {a[AW-1 -: QUAD_W], a[SOP_W+STEP_W-1:0]};
  endfunction

  assign wr_idx = idx_of(waddr);
  assign rd_idx = idx_of(raddr);

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wdata;
  end

  assign rdata = mem[rd_idx];

  assert_write_seen_R6: assert property (@(posedge clk) disable iff (rst)
    we |=> (rd_idx != $past(wr_idx)) || (rdata == $past(wdata)));
endmodule

// File: rtl/ucode_seq_top.sv
module ucode_seq_top #(
  parameter int OPC_W  = 9,
  parameter int QUAD_W = 2,
  parameter int STEP_W = 2,
  parameter int DW     = 72,
  parameter int SOP_W  = 6,
  localparam int AW    = OPC_W + QUAD_W + STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [QUAD_W-1:0] quad_i,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [DW-1:0]     ld_data,
  output logic [AW-1:0]     ucode_addr_o,
  output logic [DW-1:0]     ucode_o,
  output logic [STEP_W-1:0] step_o,
  output logic              first_o,
  output logic              last_o
);
  logic [STEP_W-1:0] step_w;
  logic              first_w, last_w;
  logic [AW-1:0]     addr_w;

  ucs_step_ctr #(.STEP_W(STEP_W)) u_step (
    .clk(clk), .rst(rst), .step(step_w), .first(first_w), .last(last_w)
  );

  ucs_addr_form #(.OPC_W(OPC_W), .QUAD_W(QUAD_W), .STEP_W(STEP_W)) u_addr (
    .clk(clk), .rst(rst), .first(first_w), .last(last_w), .step(step_w),
    .opc_i(opc_i), .quad_i(quad_i), .addr(addr_w)
  );

  ucs_store #(.AW(AW), .DW(DW), .QUAD_W(QUAD_W), .STEP_W(STEP_W),
              .SOP_W(SOP_W)) u_store (
    .clk(clk), .rst(rst), .we(ld_en), .waddr(ld_addr), .wdata(ld_data),
    .raddr(addr_w), .rdata(ucode_o)
  );

  assign ucode_addr_o = addr_w;
  assign step_o       = step_w;
  assign first_o      = first_w;
  assign last_o       = last_w;

  assert_step_field_R1: assert property (@(posedge clk) disable iff (rst)
    ucode_addr_o[STEP_W-1:0] == step_o);
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({first_o, last_o}));
  assert_last_then_first_R5: assert property (@(posedge clk) disable iff (rst)
    last_o |=> first_o);
endmodule

// File: tb/ucode_seq_top_tb_top.sv
module ucode_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [8:0]  opc_i;
  logic [1:0]  quad_i;
  logic        ld_en;
  logic [12:0] ld_addr;
  logic [71:0] ld_data;
  logic [12:0] ucode_addr_o;
  logic [71:0] ucode_o;
  logic [1:0]  step_o;
  logic        first_o, last_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  ucode_seq_top dut_i (
    .clk(clk), .rst(rst), .opc_i(opc_i), .quad_i(quad_i), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_data(ld_data), .ucode_addr_o(ucode_addr_o),
    .ucode_o(ucode_o), .step_o(step_o), .first_o(first_o), .last_o(last_o)
  );

  function automatic logic [71:0] pat(input int i);
    logic [31:0] a, b;
    a = i * 32'h9E37;
    b = i ^ 32'h5A5A0000;
    return {8'hC3, a, b};
  endfunction

  // store word number: variant bits shifted above the low byte of the address
  function automatic int widx(input logic [12:0] a);
    return ((int'(a) >> 11) & 3) * 256 + (int'(a) % 256);
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [12:0] ea;
    rst = 1'b1; ld_en = 1'b0; opc_i = '0; quad_i = '0;
    ld_addr = '0; ld_data = '0;
    repeat (2) @(negedge clk);
    #1;
    chk(step_o == 2'd0, "R2 reset step", 72'(step_o), 72'd0);
    chk(first_o && !last_o, "R5 reset strobes", {70'd0, first_o, last_o}, 72'd2);

    // R6: fill every store word while the sequencer is held in reset
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      ld_en = 1'b1;
      ld_addr = {2'(i / 256), 3'b101, 8'(i % 256)};
      ld_data = pat(i);
    end
    @(negedge clk);
    ld_en = 1'b0;
    rst = 1'b0;

    // sweep every variant and opcode; junk on inputs in steps 1..3 (R3, R4)
    for (int q = 0; q < 4; q++) begin
      for (int o = 0; o < 512; o++) begin
        for (int s = 0; s < 4; s++) begin
          opc_i  = (s == 0) ? 9'(o) : 9'(o) ^ 9'(9'h0A5 + s);
          quad_i = (s == 0) ? 2'(q) : ~2'(q);
          #1;
          ea = {2'(q), 9'(o), 2'(s)};
          chk(ucode_addr_o[1:0] == 2'(s) && step_o == 2'(s), "R1 R2 step field",
              72'(ucode_addr_o), 72'(ea));
          chk(ucode_addr_o[10:2] == 9'(o), "R3 opcode field",
              72'(ucode_addr_o[10:2]), 72'(o));
          chk(ucode_addr_o[12:11] == 2'(q), "R4 variant field",
              72'(ucode_addr_o[12:11]), 72'(q));
          chk(first_o == (s == 0) && last_o == (s == 3), "R5 strobes",
              {70'd0, first_o, last_o}, {70'd0, s == 0, s == 3});
          chk(ucode_o == pat(widx(ea)), "R6 R7 control word", ucode_o, pat(widx(ea)));
          @(negedge clk);
        end
      end
    end

    // R7: aliased opcodes 1C5 and 005 under variant 2, step 0
    opc_i = 9'h1C5; quad_i = 2'd2;
    ld_en = 1'b1;
    ld_addr = {2'd2, 9'h045, 2'd1};
    ld_data = 72'hAB_CDEF_0123_4567_89AB;
    #1;
    chk(ucode_o == pat(2 * 256 + 8'h14), "R7 alias read", ucode_o, pat(2 * 256 + 8'h14));
    @(negedge clk);
    ld_en = 1'b0;
    opc_i = 9'h000;
    #1;
    // R6: written during step 0, read through the aliased address in step 1
    chk(ucode_o == 72'hAB_CDEF_0123_4567_89AB, "R6 next-cycle write",
        ucode_o, 72'hAB_CDEF_0123_4567_89AB);
    @(negedge clk);
    #1;
    chk(step_o == 2'd2, "R2 mid step", 72'(step_o), 72'd2);
    rst = 1'b1;
    @(negedge clk);
    opc_i = 9'h045; quad_i = 2'd2;
    #1;
    chk(step_o == 2'd0 && first_o, "R8 reset mid instruction", 72'(step_o), 72'd0);
    chk(ucode_o == pat(2 * 256 + 8'h14), "R8 store kept", ucode_o, pat(2 * 256 + 8'h14));
    rst = 1'b0;
    @(negedge clk);
    opc_i = 9'h1FF; quad_i = 2'd0;
    #1;
    chk(ucode_addr_o == {2'd2, 9'h045, 2'd1}, "R3 R4 capture after reset",
        72'(ucode_addr_o), 72'({2'd2, 9'h045, 2'd1}));
    chk(ucode_o == 72'hAB_CDEF_0123_4567_89AB, "R8 written word kept",
        ucode_o, 72'hAB_CDEF_0123_4567_89AB);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule